// File: doc/BRIEF.md
# Digital Bit-Clock Regenerator

The block rebuilds a receive bit clock from the marks of a bipolar line code. It uses a local reference clock that runs at eight times the bit rate, for example 16.384 MHz for a 2.048 Mb/s link or 12.352 MHz for 1.544 Mb/s. The two receive rails are merged by an OR into a single activity signal. That signal is brought into the reference domain by a synchroniser. A small edge-tracking state machine turns each new mark into a one-cycle resync pulse. The pulse reloads a divide-by-eight phase counter, and the counter's top bit is the recovered clock. Between marks the counter keeps counting, so the clock carries on through runs of zeros.

The edge tracker has two states. `LINE_QUIET` means the synchronised activity is low. `LINE_MARK` means it is high. The transition `QUIET_TO_MARK` fires when activity rises, and it is the only transition that raises the resync pulse. The transition `MARK_TO_QUIET` fires when activity falls. The reload value is chosen so that, counting the synchroniser delay, the recovered rising edge lands half a bit after the start of the mark. With no input jitter, the recovered phase drifts in a sawtooth of at most one reference period.

A mode input picks the clock path. When it is high, the internally rebuilt clock drives the bit-clock output. When it is low, the block is bypassed: the raw ORed activity is exported for an outside recovery circuit, and the bit clock is passed through from an external input.

Top module: `bitclk_regen`

## Requirements
- R1: While reset is asserted and with the mode input high, the recovered clock output and the activity output are both 0. The phase counter restarts at 0.
- R2: A mark on either rail alone resynchronises the phase counter. The rails are combined by a logical OR.
- R3: If a rising activity edge is first captured at reference edge k, the recovered clock rises at edge k+4. This comes from the counter being loaded with 2 at edge k+2.
- R4: With no marks arriving, the recovered clock runs freely with a period of 8 reference cycles. It is high for 4 cycles (counter values 4 to 7) and low for 4 cycles.
- R5: Activity held high for many cycles gives only one resync. The counter then runs freely, and the state machine stays in `LINE_MARK` until activity falls.
- R6: While the mode input is high, the activity output is held at 0.
- R7: While the mode input is low, the bit-clock output equals the external clock input and the activity output equals rail_a OR rail_b. Both are combinational, in the same cycle.
- R8: With a transmitter whose bit period alternates between 8 and 9 reference cycles, every recovered rising edge after a mark lies within one reference period of the transmitter's mid-bit point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, eight times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_int | input | 1 | 1 selects internal regeneration, 0 selects bypass |
| rail_a | input | 1 | First receive rail (marks of one polarity) |
| rail_b | input | 1 | Second receive rail (marks of the other polarity) |
| ext_bit_clk | input | 1 | Externally recovered bit clock, used in bypass |
| activity_out | output | 1 | ORed rails in bypass, 0 otherwise |
| bit_clk_out | output | 1 | Recovered or passed-through bit clock |

## Verification
A mark that is driven between edges is captured at the next reference edge k. It reaches the counter as a reload at edge k+2 and shows as a rising recovered clock after edge k+4. The bench model therefore advances its own counter at every edge from delayed copies of the sampled rails. It compares the model with the output half a cycle later, at the falling edge. The rise-timing checks measure the distance from the capture edge to the observed rise, and they only consider rises between 2 and 7 cycles after a capture. The bypass paths are combinational, so they are checked one time step after the inputs change, with no clock edge in between.

// File: rtl/bitclk_regen_pkg.sv
package bitclk_regen_pkg;

    // Edge-tracking states of the merged line activity
    typedef enum logic [0:0] {
        LINE_QUIET = 1'b0,
        LINE_MARK  = 1'b1
    } line_state_e;

endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
    parameter int NUM_RAILS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_ref,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rails_raw,
    output logic [NUM_RAILS-1:0] rails_sync
);

    // One shift chain per rail into the reference domain
    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        logic [SYNC_STAGES-1:0] chain;

        always_ff @(posedge clk_ref or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], rails_raw[r]};
            end
        end

        assign rails_sync[r] = chain[SYNC_STAGES-1];
    end

endmodule

// File: rtl/line_edge_fsm.sv
module line_edge_fsm
    import bitclk_regen_pkg::*;
(
    input  logic clk_ref,
    input  logic rst_n,
    input  logic activity,
    output logic resync_pulse
);

    line_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: QUIET_TO_MARK on rising activity, MARK_TO_QUIET on falling
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET: if (activity)  state_d = LINE_MARK;
            LINE_MARK:  if (!activity) state_d = LINE_QUIET;
            default:    state_d = LINE_QUIET;
        endcase
    end

    // Outputs: pulse only on the QUIET_TO_MARK transition
    always_comb begin
        resync_pulse = 1'b0;
        unique case (state_q)
            LINE_QUIET: resync_pulse = activity;
            LINE_MARK:  resync_pulse = 1'b0;
            default:    resync_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int DIV      = 8,
    parameter int LOAD_VAL = 2,
    localparam int CW      = $clog2(DIV)
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          resync,
    output logic [CW-1:0] phase,
    output logic          clk_rec
);

    localparam logic [CW-1:0] LOAD_W = CW'(LOAD_VAL);

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (resync) begin
            phase <= LOAD_W;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Top bit gives a 50 % duty clock when DIV is a power of two
    assign clk_rec = phase[CW-1];

endmodule

// File: rtl/bitclk_regen.sv
module bitclk_regen #(
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic mode_int,
    input  logic rail_a,
    input  logic rail_b,
    input  logic ext_bit_clk,
    output logic activity_out,
    output logic bit_clk_out
);

    localparam int NUM_RAILS = 2;
    localparam int CW        = $clog2(DIV);
    // Reload value that puts the rising edge half a bit after the mark start
    localparam int LOAD_VAL  = SYNC_STAGES % DIV;

    logic [NUM_RAILS-1:0] rails_raw;
    logic [NUM_RAILS-1:0] rails_sync;
    logic                 act_sync;
    logic                 resync_pulse;
    logic [CW-1:0]        phase_cnt;
    logic                 clk_rec;

    assign rails_raw = {rail_b, rail_a};

    rail_sync #(
        .NUM_RAILS  (NUM_RAILS),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .rails_raw (rails_raw),
        .rails_sync(rails_sync)
    );

    assign act_sync = |rails_sync;

    line_edge_fsm u_edge (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .activity    (act_sync),
        .resync_pulse(resync_pulse)
    );

    phase_counter #(
        .DIV     (DIV),
        .LOAD_VAL(LOAD_VAL)
    ) u_cnt (
        .clk_ref(clk_ref),
        .rst_n  (rst_n),
        .resync (resync_pulse),
        .phase  (phase_cnt),
        .clk_rec(clk_rec)
    );

    // Path select: internal regeneration or bypass
    always_comb begin
        if (mode_int) begin
            bit_clk_out  = clk_rec;
            activity_out = 1'b0;
        end else begin
            bit_clk_out  = ext_bit_clk;
            activity_out = |rails_raw;
        end
    end

endmodule

// File: rtl/bitclk_regen_chk.sv
module bitclk_regen_chk #(
    parameter int CW       = 3,
    parameter int LOAD_VAL = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode,
    input logic          ra,
    input logic          rb,
    input logic          ext,
    input logic          act,
    input logic          bclk,
    input logic          act_s,
    input logic          pulse,
    input logic [CW-1:0] cnt
);

    assert_pulse_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_s) |-> pulse);

    assert_load_after_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (cnt == CW'(LOAD_VAL)));

    assert_free_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> (cnt == CW'($past(cnt) + 1'b1)));

    assert_single_resync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    assert_quiet_activity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> !act);

    assert_bypass_paths_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> ((bclk == ext) && (act == (ra | rb))));

endmodule

bind bitclk_regen bitclk_regen_chk #(
    .CW      (CW),
    .LOAD_VAL(LOAD_VAL)
) u_chk (
    .clk  (clk_ref),
    .rst_n(rst_n),
    .mode (mode_int),
    .ra   (rail_a),
    .rb   (rail_b),
    .ext  (ext_bit_clk),
    .act  (activity_out),
    .bclk (bit_clk_out),
    .act_s(act_sync),
    .pulse(resync_pulse),
    .cnt  (phase_cnt)
);

// File: tb/bitclk_regen_tb_top.sv
module bitclk_regen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_int = 1'b1;
    logic rail_a = 1'b0;
    logic rail_b = 1'b0;
    logic ext_bit_clk = 1'b0;
    logic activity_out;
    logic bit_clk_out;

    always #5 clk = ~clk;

    bitclk_regen dut_i (
        .clk_ref     (clk),
        .rst_n       (rst_n),
        .mode_int    (mode_int),
        .rail_a      (rail_a),
        .rail_b      (rail_b),
        .ext_bit_clk (ext_bit_clk),
        .activity_out(activity_out),
        .bit_clk_out (bit_clk_out)
    );

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string phase_req = "R4";
    bit    offset_phase = 0;
    int    cur_period = 8;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: sampled-rail history and an integer phase
    int cyc = 0;
    int h1 = 0, h2 = 0, st = 0, mcnt = 0, prev_raw = 0;
    int last_cap = -100;

    always @(posedge clk) begin
        int raw, pulse;
        cyc++;
        if (!rst_n) begin
            h1 = 0; h2 = 0; st = 0; mcnt = 0; prev_raw = 0;
        end else begin
            raw   = (rail_a || rail_b) ? 1 : 0;
            pulse = (h2 == 1 && st == 0) ? 1 : 0;
            mcnt  = (pulse == 1) ? 2 : (mcnt + 1) % 8;
            st = h2; h2 = h1; h1 = raw;
            if (raw == 1 && prev_raw == 0) last_cap = cyc;
            prev_raw = raw;
        end
    end

    // Compare on every clock, half a cycle after the edge
    logic prev_b = 1'b0;
    logic prev_mode = 1'b1;
    always @(negedge clk) begin
        if (rst_n && mode_int && !done) begin
            chk(bit_clk_out == (mcnt >= 4), phase_req, int'(bit_clk_out), int'(mcnt >= 4));
            chk(activity_out == 1'b0, "R6", int'(activity_out), 0);
            if (bit_clk_out && !prev_b && prev_mode) begin
                int d;
                d = cyc - last_cap;
                if (d >= 2 && d <= 7) begin
                    chk(d == 4, "R3", d, 4);
                    if (offset_phase) begin
                        int err2;
                        err2 = 2 * cyc - (2 * last_cap + cur_period);
                        chk(err2 >= -2 && err2 <= 2, "R8", err2, 0);
                    end
                end
            end
        end
        prev_b    = bit_clk_out;
        prev_mode = mode_int;
    end

    // Transmitter: RZ mark for half the bit on the chosen rail
    task automatic send_bit(input bit b, input bit on_b, input int period);
        @(negedge clk);
        cur_period = period;
        if (b) begin
            if (on_b) rail_b = 1'b1; else rail_a = 1'b1;
        end
        repeat (period / 2) @(negedge clk);
        rail_a = 1'b0;
        rail_b = 1'b0;
        repeat (period - period / 2 - 1) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lfsr;
        bit pol;
        repeat (4) @(negedge clk);
        chk(bit_clk_out == 1'b0, "R1", int'(bit_clk_out), 0);
        chk(activity_out == 1'b0, "R1", int'(activity_out), 0);
        rst_n = 1'b1;

        // R4: free-running period and duty
        phase_req = "R4";
        begin
            int t0, hi, per;
            while (!(bit_clk_out && !prev_b)) @(negedge clk);
            t0 = cyc; hi = 0;
            @(negedge clk);
            while (!(bit_clk_out && !prev_b)) begin
                if (bit_clk_out) hi++;
                @(negedge clk);
            end
            per = cyc - t0;
            chk(per == 8, "R4", per, 8);
            chk(hi == 3, "R4", hi + 1, 4);
        end

        // R2: marks on one rail only, then the other
        phase_req = "R2";
        send_bit(1, 0, 8); send_bit(1, 0, 8); send_bit(0, 0, 8); send_bit(1, 0, 8);
        send_bit(1, 1, 8); send_bit(0, 1, 8); send_bit(1, 1, 8); send_bit(1, 1, 8);
        repeat (8) @(negedge clk);

        // R8: offset-rate transmitter with zero runs
        phase_req = "R8";
        offset_phase = 1;
        lfsr = 7'h5A;
        pol = 0;
        for (int i = 0; i < 120; i++) begin
            bit b;
            b = lfsr[0] | lfsr[3];
            lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]} & 7'h7F;
            if (i % 20 > 14) b = 0;
            if (b) pol = ~pol;
            send_bit(b, pol, (i % 2 == 0) ? 9 : 8);
        end
        offset_phase = 0;

        // R5: rails held high, single resync
        phase_req = "R5";
        @(negedge clk);
        rail_a = 1'b1; rail_b = 1'b1;
        repeat (30) @(negedge clk);
        rail_a = 1'b0; rail_b = 1'b0;
        repeat (12) @(negedge clk);

        // R7: bypass paths
        mode_int = 1'b0;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            rail_a = v[0]; rail_b = v[1]; ext_bit_clk = v[2];
            #1;
            chk(activity_out == (v[0] | v[1]), "R7", int'(activity_out), int'(v[0] | v[1]));
            chk(bit_clk_out == v[2], "R7", int'(bit_clk_out), int'(v[2]));
        end
        @(negedge clk);
        rail_a = 1'b0; rail_b = 1'b0; ext_bit_clk = 1'b0;
        repeat (4) @(negedge clk);
        mode_int = 1'b1;
        phase_req = "R4";
        repeat (20) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule